// File: doc/BRIEF.md
# Privileged System Register Access Checker

This block holds a 64-bit hypervisor-level auxiliary control register and rules on every system-register read or write presented to it. A request carries the five encoding fields, a direction flag, write data, the current exception level, the effective nested-virtualization control value and two configuration flags. The configuration flags say whether the 64-bit execution state exists and whether EL2 is implemented. The block answers one cycle later with one of four outcomes: the request did not address this register, the access was performed, the instruction is undefined, or the access traps to EL2 with a syndrome class code.

A permitted read returns the register contents. A permitted write replaces all 64 bits. The low 32 bits are always visible on a separate 32-bit alias output, which is driven from the same storage. The meaning of the individual bits is left to the surrounding design.

Top module: `sysreg_access_gate`

## Requirements
- R1: After reset the register holds zero, `alias32` is zero, and `rsp_valid` and `trap_valid` are low.
- R2: A request addresses the register only when op0=3, op1=4, CRn=1, CRm=1 and op2=7, and this holds for reads and writes alike. Any other encoding responds with `rsp_kind`=0 (no match), leaves the register unchanged and raises no trap.
- R3: A matching request made while `feat_a64` is low responds with `rsp_kind`=2 (undefined) at every exception level.
- R4: A matching request from EL0 (`req_el`=0) responds with `rsp_kind`=2.
- R5: A matching request from EL1 responds with `rsp_kind`=3 (trap) when bit 0 of `nv_ctrl` is set and EL2 is implemented. In that case `trap_valid` pulses for exactly that response cycle, `trap_ec` is 0x18 and `trap_is_read` is 1 for a read. In every other case the EL1 request responds with `rsp_kind`=2.
- R6: With EL2 implemented, a matching request from EL2 or EL3 responds with `rsp_kind`=1 (access). A write stores all 64 bits at the edge that registers the response. A read returns the full register.
- R7: With EL2 absent, an EL3 access responds with `rsp_kind`=1, a read returns zero and a write leaves the register unchanged. EL1 and EL2 requests respond with `rsp_kind`=2.
- R8: `alias32` always equals bits [31:0] of the register, including straight after a write.
- R9: `rsp_valid` is high exactly one cycle after `req_valid`. `rsp_rdata` carries the value held before that request, and it is zero for any response that is not a performed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| req_el | input | 2 | Current exception level |
| nv_ctrl | input | 3 | Effective nested-virtualization control value |
| feat_a64 | input | 1 | 64-bit execution state implemented |
| el2_present | input | 1 | EL2 implemented |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 0 no match, 1 access, 2 undefined, 3 trap |
| rsp_rdata | output | 64 | Read data |
| trap_valid | output | 1 | Trap pulse |
| trap_ec | output | 6 | Syndrome class of the trap |
| trap_is_read | output | 1 | Trapped access was a read |
| alias32 | output | 32 | Low-half 32-bit view of the register |

## Verification
On every cycle the assertions check the rules that need only a one-cycle look back. These are the response following each request, the undefined result for EL0 and for a missing 64-bit feature, trap pulses that appear only inside a trap response with the correct class, and a register that stays unchanged after a non-matching request. Other behaviour depends on earlier history and only the bench's scenarios can show it. This includes the contents returned by a read after a sequence of writes, zero read data from EL3 when EL2 is absent, a write being ignored in that case, and the alias staying in agreement with the full register.

// File: rtl/sysreg_access_gate.sv
module sysreg_access_gate #(
  parameter int          DW     = 64,
  parameter int          AW     = 32,
  parameter int          ECW    = 6,
  parameter logic [5:0]  TRAPEC = 6'h18,
  parameter logic [1:0]  ENC_OP0 = 2'b11,
  parameter logic [2:0]  ENC_OP1 = 3'b100,
  parameter logic [3:0]  ENC_CRN = 4'b0001,
  parameter logic [3:0]  ENC_CRM = 4'b0001,
  parameter logic [2:0]  ENC_OP2 = 3'b111
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [1:0]     req_op0,
  input  logic [2:0]     req_op1,
  input  logic [3:0]     req_crn,
  input  logic [3:0]     req_crm,
  input  logic [2:0]     req_op2,
  input  logic           req_write,
  input  logic [DW-1:0]  req_wdata,
  input  logic [1:0]     req_el,
  input  logic [2:0]     nv_ctrl,
  input  logic           feat_a64,
  input  logic           el2_present,
  output logic           rsp_valid,
  output logic [1:0]     rsp_kind,
  output logic [DW-1:0]  rsp_rdata,
  output logic           trap_valid,
  output logic [ECW-1:0] trap_ec,
  output logic           trap_is_read,
  output logic [AW-1:0]  alias32
);
  localparam logic [1:0] K_NONE = 2'd0, K_ACC = 2'd1, K_UND = 2'd2, K_TRAP = 2'd3;

  logic [DW-1:0] store;
  logic [1:0]    kind_c;
  logic          hit, do_read, do_write;

  assign hit = (req_op0 == ENC_OP0) && (req_op1 == ENC_OP1) && (req_crn == ENC_CRN) &&
               (req_crm == ENC_CRM) && (req_op2 == ENC_OP2);

  always_comb begin
    kind_c = K_NONE;
    if (hit) begin
      if (!feat_a64) kind_c = K_UND;
      else begin
        case (req_el)
          2'd0: kind_c = K_UND;
          2'd1: kind_c = (nv_ctrl[0] && el2_present) ? K_TRAP : K_UND;
          2'd2: kind_c = el2_present ? K_ACC : K_UND;
          default: kind_c = K_ACC;
        endcase
      end
    end
  end

  assign do_read  = req_valid && (kind_c == K_ACC) && !req_write;
  assign do_write = req_valid && (kind_c == K_ACC) && req_write && el2_present;
  assign alias32  = store[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store        <= '0;
      rsp_valid    <= 1'b0;
      rsp_kind     <= K_NONE;
      rsp_rdata    <= '0;
      trap_valid   <= 1'b0;
      trap_ec      <= '0;
      trap_is_read <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_kind     <= req_valid ? kind_c : K_NONE;
      rsp_rdata    <= (do_read && el2_present) ? store : '0;
      trap_valid   <= req_valid && (kind_c == K_TRAP);
      trap_ec      <= (req_valid && (kind_c == K_TRAP)) ? TRAPEC : '0;
      trap_is_read <= req_valid && (kind_c == K_TRAP) && !req_write;
      if (do_write) store <= req_wdata;
    end
  end

  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !trap_valid);
  p_el0_undef_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hit && req_el == 2'd0 |=> rsp_kind == K_UND);
  p_nofeat_undef_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hit && !feat_a64 |=> rsp_kind == K_UND);
  p_trap_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> rsp_valid && rsp_kind == K_TRAP && trap_ec == TRAPEC);
  p_nomatch_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hit |=> $stable(store) && !trap_valid && rsp_kind == K_NONE);
endmodule

// File: tb/tb_sysreg_access_gate.sv
module tb_sysreg_access_gate;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, feat_a64 = 1, el2_present = 1;
  logic [1:0] req_op0 = 0, req_el = 0;
  logic [2:0] req_op1 = 0, req_op2 = 0, nv_ctrl = 0;
  logic [3:0] req_crn = 0, req_crm = 0;
  logic [63:0] req_wdata = 0;
  logic rsp_valid, trap_valid, trap_is_read;
  logic [1:0] rsp_kind;
  logic [63:0] rsp_rdata;
  logic [5:0] trap_ec;
  logic [31:0] alias32;

  int total = 0, bad = 0;
  logic [63:0] mreg = 0;

  always #10 clk = ~clk;

  sysreg_access_gate dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model_kind(input bit hit, input bit feat, input logic [1:0] el,
                                            input logic [2:0] nv, input bit e2);
    if (!hit) return 2'd0;
    if (!feat) return 2'd2;
    case (el)
      2'd0: return 2'd2;
      2'd1: return (nv[0] && e2) ? 2'd3 : 2'd2;
      2'd2: return e2 ? 2'd1 : 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  task automatic access(input bit hitenc, input logic [1:0] o0, input logic [2:0] o1,
                        input logic [3:0] cn, input logic [3:0] cm, input logic [2:0] o2,
                        input bit wr, input logic [63:0] wd, input logic [1:0] el,
                        input logic [2:0] nv, input bit feat, input bit e2, input string tag);
    logic [1:0] ek;
    logic [63:0] er;
    bit hit;
    if (hitenc) begin o0 = 2'b11; o1 = 3'b100; cn = 4'b0001; cm = 4'b0001; o2 = 3'b111; end
    hit = (o0 == 2'b11) && (o1 == 3'b100) && (cn == 1) && (cm == 1) && (o2 == 3'b111);
    req_valid = 1; req_op0 = o0; req_op1 = o1; req_crn = cn; req_crm = cm; req_op2 = o2;
    req_write = wr; req_wdata = wd; req_el = el; nv_ctrl = nv; feat_a64 = feat; el2_present = e2;
    ek = model_kind(hit, feat, el, nv, e2);
    er = (ek == 2'd1 && !wr && e2) ? mreg : 64'd0;
    @(negedge clk);
    req_valid = 0;
    if (ek == 2'd1 && wr && e2) mreg = wd;
    chk(rsp_valid === 1'b1, {tag, " R9 valid"}, rsp_valid, 1);
    chk(rsp_kind === ek, {tag, " kind"}, rsp_kind, ek);
    chk(rsp_rdata === er, {tag, " R9 rdata"}, rsp_rdata, er);
    chk(trap_valid === (ek == 2'd3), {tag, " R5 trap_valid"}, trap_valid, ek == 2'd3);
    chk(trap_ec === ((ek == 2'd3) ? 6'h18 : 6'h0), {tag, " R5 trap_ec"}, trap_ec, 6'h18);
    chk(trap_is_read === (ek == 2'd3 && !wr), {tag, " R5 dir"}, trap_is_read, !wr);
    chk(alias32 === mreg[31:0], {tag, " R8 alias"}, alias32, mreg[31:0]);
  endtask

  task automatic read_back(input string tag);
    access(1, 0, 0, 0, 0, 0, 0, 64'd0, 2'd2, 3'd0, 1, 1, tag);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk(!rsp_valid && !trap_valid, {tag, " R9/R5 idle"}, {rsp_valid, trap_valid}, 0);
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(rsp_valid === 0 && trap_valid === 0, "R1 reset outputs", {rsp_valid, trap_valid}, 0);
    chk(alias32 === 0, "R1 reset alias", alias32, 0);
    read_back("R1 reset read");

    access(1, 0, 0, 0, 0, 0, 1, 64'hDEAD_BEEF_1234_5678, 2'd2, 0, 1, 1, "R6 el2 write");
    read_back("R6 el2 readback");
    access(1, 0, 0, 0, 0, 0, 1, 64'h0BAD_F00D_CAFE_0001, 2'd3, 0, 1, 1, "R6 el3 write");
    access(1, 0, 0, 0, 0, 0, 0, 0, 2'd3, 0, 1, 1, "R6 el3 read");
    access(0, 2'b11, 3'b100, 4'd1, 4'd1, 3'b110, 1, 64'h1, 2'd3, 0, 1, 1, "R2 op2 miss");
    access(0, 2'b11, 3'b000, 4'd1, 4'd1, 3'b111, 1, 64'h2, 2'd2, 0, 1, 1, "R2 op1 miss");
    read_back("R2 unchanged");
    access(1, 0, 0, 0, 0, 0, 1, 64'h5, 2'd3, 3'd1, 0, 1, "R3 nofeat el3");
    access(1, 0, 0, 0, 0, 0, 0, 0, 2'd1, 3'd1, 0, 1, "R3 nofeat el1");
    access(1, 0, 0, 0, 0, 0, 1, 64'h7, 2'd0, 3'd7, 1, 1, "R4 el0 write");
    access(1, 0, 0, 0, 0, 0, 0, 64'h0, 2'd1, 3'd1, 1, 1, "R5 el1 trap read");
    idle_check("R5 pulse");
    access(1, 0, 0, 0, 0, 0, 1, 64'h9, 2'd1, 3'd1, 1, 1, "R5 el1 trap write");
    access(1, 0, 0, 0, 0, 0, 1, 64'h9, 2'd1, 3'd6, 1, 1, "R5 el1 undef");
    read_back("R5 unchanged");
    access(1, 0, 0, 0, 0, 0, 1, 64'hFFFF_0000_FFFF_0000, 2'd3, 0, 1, 0, "R7 el3 write ignored");
    access(1, 0, 0, 0, 0, 0, 0, 0, 2'd3, 0, 1, 0, "R7 el3 read zero");
    access(1, 0, 0, 0, 0, 0, 0, 0, 2'd2, 0, 1, 0, "R7 el2 undef");
    access(1, 0, 0, 0, 0, 0, 0, 0, 2'd1, 3'd1, 1, 0, "R7 el1 undef");
    read_back("R7 unchanged");

    for (int i = 0; i < 400; i++) begin
      bit hitenc = ($urandom % 4) != 0;
      access(hitenc, 2'($urandom), 3'($urandom), 4'($urandom), 4'($urandom), 3'($urandom),
             1'($urandom), {$urandom, $urandom}, 2'($urandom), 3'($urandom),
             ($urandom % 8) != 0, ($urandom % 6) != 0, "R2/R6 random");
      if (($urandom % 5) == 0) idle_check("R9 random idle");
    end
    read_back("R8 final");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule